// File: doc/BRIEF.md
# Dual-Port Receiver Scan Controller

This block sequences a two-input video receiver that can listen on only one of its inputs at a time. After reset it first keeps the receiver in reset for a programmable number of cycles. It then waits a settle interval. After that it enables hot-plug on both inputs and starts looking for a source on port 1.

While no source is reported, the controller alternates between the two ports. It stays on each port for a dwell window of `CLK_HZ * DWELL_SEC` clock cycles, which is three seconds by default. When the synchronised source-detect input goes high, scanning stops and the current port is held. The lock status stays high for as long as the source remains present. When the source goes away, the dwell window restarts on that same port before any further switching.

The active-low receiver interrupt is synchronised. Each new assertion of it while scanning restarts the dwell window, so a pending status change gets a full window on the current port.

Top module: `rx_port_scanner`

## Requirements
- R1: `rxRstN` is 0 while `rst_n` is low and for exactly `RST_CYCLES` clock cycles after reset is released; it then stays 1 until the next reset.
- R2: Both bits of `hpdEnN` are 1 during the reset hold and the following `SETTLE_CYCLES` cycles. Both then become 0 together and stay 0 until the next reset.
- R3: `portSel` is 1 (port 1) during reset and is the first port scanned.
- R4: With no source detected, `portSel` inverts every `CLK_HZ * DWELL_SEC` cycles during scanning, and it never changes at any other time. The first switch comes that many cycles after scanning starts.
- R5: A high `srcDetect` during scanning raises `locked` on the third rising edge after it is first sampled (two synchronising flops plus the state register). `portSel` is then held for as long as the source stays present.
- R6: When `srcDetect` drops while locked, `locked` falls on the third edge after the low value is first sampled. A full dwell window then restarts on the same port.
- R7: While scanning, a high-to-low transition of `rxIntN` (seen through two synchronising flops) restarts the dwell window on the current port. Holding `rxIntN` low, or its return to high, has no further effect.
- R8: `srcDetect` is ignored during the reset hold and the settle interval. A source already present at that time locks on the first edge after scanning starts.
- R9: `locked` is high only if `srcDetect` was high when sampled three edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srcDetect | input | 1 | Receiver reports an attached, synchronised source (asynchronous) |
| rxIntN | input | 1 | Receiver interrupt, active low (asynchronous) |
| rxRstN | output | 1 | Receiver reset, active low |
| portSel | output | 1 | Active receive port: 1 = port 1, 0 = port 0 |
| hpdEnN | output | 2 | Per-port hot-plug enables, active low, bit n = port n |
| locked | output | 1 | A source is present on the selected port |

## Verification
The bench first lets the block scan with no source, which shows the dwell period and the alternation order. It then locks on port 0 and later on port 1, which shows the block holds whichever port it is on when a source appears. Each source drop is followed by a check one cycle before and one cycle at the expected switch. This separates a restarted window from one that keeps its old count. A single interrupt pulse that is held low for several cycles shows whether only the falling edge restarts the window. A final reset with the source already present checks that detection is masked until scanning begins.

// File: rtl/rxscan_pkg.sv
package rxscan_pkg;

  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SCAN   = 2'd2,
    ST_LOCK   = 2'd3
  } scanState_t;

  // Strobes from control to datapath; clear has priority over run.
  typedef struct packed {
    logic cntClear;
    logic cntRun;
    logic portFlip;
  } scanStrobe_t;

endpackage

// File: rtl/rxscan_datapath.sv
module rxscan_datapath
  import rxscan_pkg::*;
#(
  parameter int RST_CYC    = 16,
  parameter int SETTLE_CYC = 64,
  parameter int DWELL_CYC  = 81_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        srcDetect,
  input  logic        rxIntN,
  input  scanStrobe_t strobe,
  output logic        srcSeen,
  output logic        intFall,
  output logic        rstDone,
  output logic        settleDone,
  output logic        dwellDone,
  output logic        portSel
);

  localparam int MAX_A = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int MAX_C = (MAX_A > DWELL_CYC) ? MAX_A : DWELL_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic [CNT_W-1:0] cnt;
  logic             srcMeta;
  logic             intMeta, intSync, intPrev;

  // Shared phase counter.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (strobe.cntClear) cnt <= '0;
    else if (strobe.cntRun)   cnt <= cnt + CNT_W'(1);
  end

  assign rstDone    = (cnt == CNT_W'(RST_CYC - 1));
  assign settleDone = (cnt == CNT_W'(SETTLE_CYC - 1));
  assign dwellDone  = (cnt == CNT_W'(DWELL_CYC - 1));

  // Two-flop synchroniser for source detect.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcMeta <= 1'b0;
      srcSeen <= 1'b0;
    end else begin
      srcMeta <= srcDetect;
      srcSeen <= srcMeta;
    end
  end

  // Interrupt synchroniser plus edge detector (idle high).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intMeta <= 1'b1;
      intSync <= 1'b1;
      intPrev <= 1'b1;
    end else begin
      intMeta <= rxIntN;
      intSync <= intMeta;
      intPrev <= intSync;
    end
  end

  assign intFall = intPrev & ~intSync;

  // Active port register, port 1 after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               portSel <= 1'b1;
    else if (strobe.portFlip) portSel <= ~portSel;
  end

endmodule

// File: rtl/rxscan_ctrl.sv
module rxscan_ctrl
  import rxscan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        srcSeen,
  input  logic        intFall,
  input  logic        rstDone,
  input  logic        settleDone,
  input  logic        dwellDone,
  output scanStrobe_t strobe,
  output scanState_t  state
);

  scanState_t stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_HOLD;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_HOLD: begin
        strobe.cntRun = 1'b1;
        if (rstDone) begin
          stateNext       = ST_SETTLE;
          strobe.cntClear = 1'b1;
        end
      end
      ST_SETTLE: begin
        strobe.cntRun = 1'b1;
        if (settleDone) begin
          stateNext       = ST_SCAN;
          strobe.cntClear = 1'b1;
        end
      end
      ST_SCAN: begin
        if (srcSeen) begin
          stateNext       = ST_LOCK;
          strobe.cntClear = 1'b1;
        end else if (intFall) begin
          strobe.cntClear = 1'b1;
        end else if (dwellDone) begin
          strobe.portFlip = 1'b1;
          strobe.cntClear = 1'b1;
        end else begin
          strobe.cntRun = 1'b1;
        end
      end
      ST_LOCK: begin
        strobe.cntClear = 1'b1;
        if (!srcSeen) stateNext = ST_SCAN;
      end
      default: stateNext = ST_HOLD;
    endcase
  end

endmodule

// File: rtl/rx_port_scanner.sv
module rx_port_scanner
  import rxscan_pkg::*;
#(
  parameter int CLK_HZ        = 27_000_000,
  parameter int DWELL_SEC     = 3,
  parameter int RST_CYCLES    = 16,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srcDetect,
  input  logic       rxIntN,
  output logic       rxRstN,
  output logic       portSel,
  output logic [1:0] hpdEnN,
  output logic       locked
);

  localparam int DWELL_CYC = CLK_HZ * DWELL_SEC;

  scanStrobe_t strobe;
  scanState_t  state;
  logic        srcSeen, intFall, rstDone, settleDone, dwellDone;

  rxscan_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .srcSeen    (srcSeen),
    .intFall    (intFall),
    .rstDone    (rstDone),
    .settleDone (settleDone),
    .dwellDone  (dwellDone),
    .strobe     (strobe),
    .state      (state)
  );

  rxscan_datapath #(
    .RST_CYC    (RST_CYCLES),
    .SETTLE_CYC (SETTLE_CYCLES),
    .DWELL_CYC  (DWELL_CYC)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .srcDetect  (srcDetect),
    .rxIntN     (rxIntN),
    .strobe     (strobe),
    .srcSeen    (srcSeen),
    .intFall    (intFall),
    .rstDone    (rstDone),
    .settleDone (settleDone),
    .dwellDone  (dwellDone),
    .portSel    (portSel)
  );

  assign rxRstN = (state != ST_HOLD);
  assign hpdEnN = ((state == ST_SCAN) || (state == ST_LOCK)) ? 2'b00 : 2'b11;
  assign locked = (state == ST_LOCK);

endmodule

// File: rtl/rx_port_scanner_chk.sv
module rx_port_scanner_chk #(
  parameter int DWELL_CYC = 81_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       srcDetect,
  input logic       rxRstN,
  input logic       portSel,
  input logic [1:0] hpdEnN,
  input logic       locked
);

  logic [31:0] gap;
  logic        portQ;

  // Cycles since the last port change (saturating).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap   <= '0;
      portQ <= 1'b1;
    end else begin
      portQ <= portSel;
      if (portSel != portQ)  gap <= '0;
      else if (gap != '1)    gap <= gap + 32'd1;
    end
  end

  assert_rst_no_refall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(rxRstN));

  assert_hpd_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hpdEnN[0] == hpdEnN[1]) && !$rose(hpdEnN[0]));

  assert_hpd_after_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rxRstN |-> hpdEnN == 2'b11);

  assert_switch_only_scanning_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(portSel) |-> ($past(hpdEnN) == 2'b00) && !$past(locked));

  assert_dwell_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (portSel != portQ) |-> gap >= 32'(DWELL_CYC - 1));

  assert_lock_holds_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(portSel));

  assert_lock_needs_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> $past(srcDetect, 3));

endmodule

bind rx_port_scanner rx_port_scanner_chk #(.DWELL_CYC(CLK_HZ * DWELL_SEC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .srcDetect (srcDetect),
  .rxRstN    (rxRstN),
  .portSel   (portSel),
  .hpdEnN    (hpdEnN),
  .locked    (locked)
);

// File: tb/rx_port_scanner_bench.sv
`timescale 1ns/1ps
module rx_port_scanner_bench;

  localparam int CLK_HZ = 50;
  localparam int DWELL_SEC = 3;
  localparam int RST_CYCLES = 4;
  localparam int SETTLE_CYCLES = 6;
  localparam int NROWS = 26;

  typedef struct packed {
    logic [15:0] edgeN;
    logic        rstN;
    logic [1:0]  hpd;
    logic        port;
    logic        lk;
    logic        src;   // level driven after the check
    logic        intN;  // level driven after the check
    logic [23:0] tag;
  } row_t;

  // Dwell = 150 cycles, scan starts after edge 10.
  localparam row_t ROWS [NROWS] = '{
    '{16'd1,   1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, "R1"},
    '{16'd3,   1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, "R1"},
    '{16'd4,   1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, "R1"},
    '{16'd9,   1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, "R2"},
    '{16'd10,  1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, "R2"},
    '{16'd159, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, "R3"},
    '{16'd160, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R4"},
    '{16'd170, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, "R4"},
    '{16'd172, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, "R5"},
    '{16'd173, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, "R5"},
    '{16'd200, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, "R5"},
    '{16'd202, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, "R6"},
    '{16'd203, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R6"},
    '{16'd352, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R6"},
    '{16'd353, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, "R6"},
    '{16'd360, 1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, "R4"},
    '{16'd363, 1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, "R5"},
    '{16'd600, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, "R5"},
    '{16'd603, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, "R6"},
    '{16'd752, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, "R6"},
    '{16'd753, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R4"},
    '{16'd800, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R4"},
    '{16'd810, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R7"},
    '{16'd903, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R7"},
    '{16'd952, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R7"},
    '{16'd953, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, "R7"}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       srcDetect = 1'b0;
  logic       rxIntN = 1'b1;
  logic       rxRstN, portSel, locked;
  logic [1:0] hpdEnN;

  int total = 0;
  int bad = 0;
  int edgeCnt = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rx_port_scanner #(
    .CLK_HZ(CLK_HZ), .DWELL_SEC(DWELL_SEC),
    .RST_CYCLES(RST_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_rx_port_scanner (
    .clk(clk), .rst_n(rst_n), .srcDetect(srcDetect), .rxIntN(rxIntN),
    .rxRstN(rxRstN), .portSel(portSel), .hpdEnN(hpdEnN), .locked(locked)
  );

  always @(posedge clk) begin
    if (!rst_n) edgeCnt <= 0;
    else        edgeCnt <= edgeCnt + 1;
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic checkOuts(input logic [23:0] tag, input logic eRst,
                           input logic [1:0] eHpd, input logic ePort, input logic eLk);
    logic [4:0] act, exp;
    act = {rxRstN, hpdEnN, portSel, locked};
    exp = {eRst, eHpd, ePort, eLk};
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s edge=%0d {rxRstN,hpdEnN,portSel,locked} actual=%b expected=%b",
               tag, edgeCnt, act, exp);
    end
  endtask

  task automatic waitEdge(input int n);
    while (edgeCnt < n) @(negedge clk);
  endtask

  task automatic applyReset(input logic srcLvl);
    @(negedge clk);
    rst_n = 1'b0;
    srcDetect = srcLvl;
    rxIntN = 1'b1;
    repeat (3) @(negedge clk);
    // Reset state: R1 receiver held, R2 hot-plug off, R3 port 1.
    checkOuts("R1", 1'b0, 2'b11, 1'b1, 1'b0);
    checkOuts("R3", 1'b0, 2'b11, 1'b1, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    applyReset(1'b0);
    for (int i = 0; i < NROWS; i++) begin
      waitEdge(int'(ROWS[i].edgeN));
      checkOuts(ROWS[i].tag, ROWS[i].rstN, ROWS[i].hpd, ROWS[i].port, ROWS[i].lk);
      srcDetect = ROWS[i].src;
      rxIntN = ROWS[i].intN;
    end

    // R8: source present from reset is masked until scanning begins.
    applyReset(1'b1);
    waitEdge(4);
    checkOuts("R8", 1'b1, 2'b11, 1'b1, 1'b0);
    waitEdge(10);
    checkOuts("R8", 1'b1, 2'b00, 1'b1, 1'b0);
    waitEdge(11);
    checkOuts("R8", 1'b1, 2'b00, 1'b1, 1'b1);
    // R9: lock drops after source removal.
    srcDetect = 1'b0;
    waitEdge(14);
    checkOuts("R9", 1'b1, 2'b00, 1'b1, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule